// File: doc/BRIEF.md
# Interrupt Priority Mask Controller

The block sits between a set of already-synchronized interrupt request lines and a CPU's single interrupt input. Each request source owns a programmable priority level. While the controller is enabled, a pending request is eligible only when its level is equal to or above the current priority mask. Among the eligible requests the controller picks one. It forwards a valid flag, the source index and that source's level.

When the CPU acknowledges the forwarded request, the mask rises to the level of the acknowledged source. In the same cycle the old mask is saved in a shallow shift-register history. A pull strobe from software takes the most recent saved value back out and makes it the mask again. Flags report when the history is full and when it is empty.

While the enable is low the controller does not filter. Requests pass to the selector as they are, and acknowledge and pull strobes are ignored. Raw asynchronous lines and clock wake-up paths are handled elsewhere.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask is 0, the empty flag is 1, the full flag is 0 and every source level is 0.
- R2: While enabled, a request is forwarded only if its source level is greater than or equal to the current mask; a level equal to the mask passes.
- R3: The forwarded request is the eligible one with the highest level; ties go to the lowest source index; valid is 0 when nothing is eligible; valid, index and level follow the inputs in the same cycle.
- R4: While disabled, every pending request is eligible regardless of the mask, and acknowledge and pull strobes change neither the mask nor the history.
- R5: An acknowledge while enabled and valid loads the mask with the forwarded level on the next clock edge and pushes the old mask onto the history in the same edge.
- R6: A pull while enabled and the history is not empty restores the most recently pushed value as the mask on the next edge (last in, first out).
- R7: The full flag is 1 once four values are held; a push while full discards the oldest value and the full flag stays 1; a pull clears it.
- R8: The empty flag is 1 once every pushed value has been pulled; a pull while empty leaves the mask unchanged.
- R9: A level write changes the source's level from the next edge on; an accepted acknowledge in the same cycle as a pull wins, and the pull is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Controller enable; low passes requests unfiltered |
| req_i | input | NUM_SRC (8) | Synchronized request lines, bit n = source n |
| lvl_wr_i | input | 1 | Level register write strobe |
| lvl_wr_idx_i | input | IDX_W (3) | Source whose level is written |
| lvl_wr_data_i | input | LVL_W (2) | New level, 0 lowest, 3 highest |
| ack_i | input | 1 | CPU acknowledge of the forwarded request |
| pull_i | input | 1 | Write-1 pull strobe that restores the saved mask |
| irq_valid_o | output | 1 | A request is forwarded |
| irq_idx_o | output | IDX_W (3) | Index of the forwarded source |
| irq_lvl_o | output | LVL_W (2) | Level of the forwarded source |
| mask_o | output | LVL_W (2) | Current priority mask |
| stack_full_o | output | 1 | History holds four values |
| stack_empty_o | output | 1 | History holds no value |

## Verification
Forward valid, index and level depend only on inputs and registered state, so they are due in the cycle of the stimulus. The bench drives on the falling edge and samples one nanosecond later, before the next rising edge. Mask, full and empty flags and written levels change on the first rising edge after the strobe. The bench therefore drops every strobe at the next falling edge and samples those outputs there, exactly one edge after the strobe was captured.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int unsigned DEF_NUM_SRC     = 8;
  localparam int unsigned DEF_LVL_W       = 2;
  localparam int unsigned DEF_STACK_DEPTH = 4;

  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_PULL = 2'd2
  } stk_op_e;
endpackage

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned LVL_W   = 2,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [LVL_W-1:0]                wr_data_i,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
    logic hit;
    assign hit = wr_i && (wr_idx_i == IDX_W'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  lvl_o[s] <= '0;
      else if (hit) lvl_o[s] <= wr_data_i;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned LVL_W   = 2,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                            enable_i,
  input  logic [NUM_SRC-1:0]              req_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_i,
  input  logic [LVL_W-1:0]                mask_i,
  output logic                            valid_o,
  output logic [IDX_W-1:0]                idx_o,
  output logic [LVL_W-1:0]                lvl_o
);
  logic [NUM_SRC-1:0] elig;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_elig
    assign elig[s] = req_i[s] && (!enable_i || (lvl_i[s] >= mask_i));
  end

  // downward scan with >= lets the lowest index win a tie
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (!valid_o || (lvl_i[i] >= lvl_o))) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_mask_stack.sv
module irq_mask_stack
  import irq_mask_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LVL_W  = 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  input  logic [LVL_W-1:0] push_data_i,
  output logic [LVL_W-1:0] top_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [DEPTH-1:0][LVL_W-1:0] ent_q;
  logic [CNT_W-1:0]            cnt_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    logic [LVL_W-1:0] from_up, from_dn;
    if (k == 0) begin : g_head
      assign from_up = push_data_i;
    end else begin : g_mid
      assign from_up = ent_q[k-1];
    end
    if (k == DEPTH - 1) begin : g_tail
      assign from_dn = '0;
    end else begin : g_body
      assign from_dn = ent_q[k+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[k] <= '0;
      end else begin
        unique case (op_i)
          STK_PUSH: ent_q[k] <= from_up;
          STK_PULL: if (cnt_q != '0) ent_q[k] <= from_dn;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        STK_PUSH: if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
        STK_PULL: if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
        default:  ;
      endcase
    end
  end

  assign top_o   = ent_q[0];
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int unsigned NUM_SRC     = DEF_NUM_SRC,
  parameter int unsigned LVL_W       = DEF_LVL_W,
  parameter int unsigned STACK_DEPTH = DEF_STACK_DEPTH,
  localparam int unsigned IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               lvl_wr_i,
  input  logic [IDX_W-1:0]   lvl_wr_idx_i,
  input  logic [LVL_W-1:0]   lvl_wr_data_i,
  input  logic               ack_i,
  input  logic               pull_i,
  output logic               irq_valid_o,
  output logic [IDX_W-1:0]   irq_idx_o,
  output logic [LVL_W-1:0]   irq_lvl_o,
  output logic [LVL_W-1:0]   mask_o,
  output logic               stack_full_o,
  output logic               stack_empty_o
);
  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
  logic [LVL_W-1:0]              mask_q, stk_top;
  logic                          ack_ok, pull_ok;
  stk_op_e                       stk_op;

  irq_lvl_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_lvl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (lvl_wr_i),
    .wr_idx_i  (lvl_wr_idx_i),
    .wr_data_i (lvl_wr_data_i),
    .lvl_o     (src_lvl)
  );

  irq_prio_sel #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_sel (
    .enable_i (enable_i),
    .req_i    (req_i),
    .lvl_i    (src_lvl),
    .mask_i   (mask_q),
    .valid_o  (irq_valid_o),
    .idx_o    (irq_idx_o),
    .lvl_o    (irq_lvl_o)
  );

  // acknowledge outranks pull in the same cycle
  assign ack_ok  = enable_i && ack_i && irq_valid_o;
  assign pull_ok = enable_i && pull_i && !ack_ok && !stack_empty_o;

  always_comb begin
    if (ack_ok)       stk_op = STK_PUSH;
    else if (pull_ok) stk_op = STK_PULL;
    else              stk_op = STK_HOLD;
  end

  irq_mask_stack #(.DEPTH(STACK_DEPTH), .LVL_W(LVL_W)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (stk_op),
    .push_data_i (mask_q),
    .top_o       (stk_top),
    .full_o      (stack_full_o),
    .empty_o     (stack_empty_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (ack_ok)  mask_q <= irq_lvl_o;
    else if (pull_ok) mask_q <= stk_top;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_mask_chk.sv
module irq_mask_chk #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned LVL_W   = 2,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic [NUM_SRC-1:0] req_i,
  input logic               ack_i,
  input logic               pull_i,
  input logic               irq_valid_o,
  input logic [IDX_W-1:0]   irq_idx_o,
  input logic [LVL_W-1:0]   irq_lvl_o,
  input logic [LVL_W-1:0]   mask_o,
  input logic               stack_full_o,
  input logic               stack_empty_o
);
  logic acc;
  assign acc = enable_i && ack_i && irq_valid_o;

  // R1
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stack_full_o && stack_empty_o));

  // R2
  mask_filter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && irq_valid_o) |-> (irq_lvl_o >= mask_o));

  // R3
  sel_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> req_i[irq_idx_o]);

  // R3
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> !irq_valid_o);

  // R4
  dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (mask_o == $past(mask_o)) && (stack_empty_o == $past(stack_empty_o))
                  && (stack_full_o == $past(stack_full_o)));

  // R5
  ack_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (mask_o == $past(irq_lvl_o)) && !stack_empty_o);

  // R7
  full_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && stack_full_o) |=> stack_full_o);

  // R8
  empty_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && pull_i && !acc && stack_empty_o) |=> (mask_o == $past(mask_o)) && stack_empty_o);
endmodule

bind irq_mask_ctrl irq_mask_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .req_i         (req_i),
  .ack_i         (ack_i),
  .pull_i        (pull_i),
  .irq_valid_o   (irq_valid_o),
  .irq_idx_o     (irq_idx_o),
  .irq_lvl_o     (irq_lvl_o),
  .mask_o        (mask_o),
  .stack_full_o  (stack_full_o),
  .stack_empty_o (stack_empty_o)
);

// File: tb/irq_mask_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_mask_ctrl_tb_top;
  localparam int NSRC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en, lvl_wr, ack, pull;
  logic [7:0] req;
  logic [2:0] wr_idx, idx;
  logic [1:0] wr_data, lvl, mask;
  logic       valid, full, empty;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  irq_mask_ctrl #(.NUM_SRC(NSRC), .LVL_W(2), .STACK_DEPTH(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .req_i(req),
    .lvl_wr_i(lvl_wr), .lvl_wr_idx_i(wr_idx), .lvl_wr_data_i(wr_data),
    .ack_i(ack), .pull_i(pull), .irq_valid_o(valid), .irq_idx_o(idx),
    .irq_lvl_o(lvl), .mask_o(mask), .stack_full_o(full), .stack_empty_o(empty)
  );

  typedef struct packed {
    logic       en;
    logic [7:0] req;
    logic       ack;
    logic       exp_v;
    logic [2:0] exp_idx;
    logic [1:0] exp_mask;
  } vec_t;

  // levels: src0..7 = 0,1,2,3,1,2,3,0
  localparam vec_t VEC [15] = '{
    '{1'b1, 8'h00, 1'b0, 1'b0, 3'd0, 2'd0},  // R3 none pending
    '{1'b1, 8'h01, 1'b0, 1'b1, 3'd0, 2'd0},  // R2 level 0 at mask 0
    '{1'b1, 8'hFF, 1'b0, 1'b1, 3'd3, 2'd0},  // R3 tie at 3 -> lowest
    '{1'b1, 8'h44, 1'b0, 1'b1, 3'd6, 2'd0},  // R3 higher level wins
    '{1'b1, 8'h30, 1'b0, 1'b1, 3'd5, 2'd0},
    '{1'b1, 8'h26, 1'b0, 1'b1, 3'd2, 2'd0},
    '{1'b1, 8'h02, 1'b1, 1'b1, 3'd1, 2'd1},  // R5 mask -> 1
    '{1'b1, 8'h81, 1'b0, 1'b0, 3'd0, 2'd1},  // R2 below mask
    '{1'b1, 8'h10, 1'b0, 1'b1, 3'd4, 2'd1},  // R2 equal passes
    '{1'b1, 8'h24, 1'b1, 1'b1, 3'd2, 2'd2},  // R5 mask -> 2
    '{1'b1, 8'h12, 1'b0, 1'b0, 3'd0, 2'd2},
    '{1'b0, 8'h12, 1'b0, 1'b1, 3'd1, 2'd2},  // R4 unfiltered
    '{1'b0, 8'h08, 1'b1, 1'b1, 3'd3, 2'd2},  // R4 ack ignored
    '{1'b1, 8'h88, 1'b1, 1'b1, 3'd3, 2'd3},  // R5 mask -> 3
    '{1'b1, 8'h44, 1'b0, 1'b1, 3'd6, 2'd3}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_lvl(input int s, input int v);
    @(negedge clk);
    lvl_wr = 1'b1; wr_idx = 3'(s); wr_data = 2'(v);
    @(negedge clk);
    lvl_wr = 1'b0;
  endtask

  // strobe captured at one rising edge, result sampled at the next falling edge
  task automatic strobe(input logic a, input logic p);
    @(negedge clk);
    ack = a; pull = p;
    @(negedge clk);
    ack = 1'b0; pull = 1'b0;
    #1;
  endtask

  task automatic ack_src(input logic [7:0] r, input int exp_mask, input string tag);
    @(negedge clk);
    req = r;
    strobe(1'b1, 1'b0);
    chk(tag, mask, exp_mask);
  endtask

  task automatic pull_chk(input int exp_mask, input string tag);
    strobe(1'b0, 1'b1);
    chk(tag, mask, exp_mask);
  endtask

  initial begin
    en = 1'b1; req = '0; lvl_wr = 1'b0; wr_idx = '0; wr_data = '0; ack = 1'b0; pull = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 mask", mask, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 idle valid", valid, 0);
    @(negedge clk); req = 8'h80; #1;
    chk("R1 level reset src7 lvl", lvl, 0);

    set_lvl(1, 1); set_lvl(2, 2); set_lvl(3, 3);
    set_lvl(4, 1); set_lvl(5, 2); set_lvl(6, 3);

    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      en = VEC[i].en; req = VEC[i].req;
      #1;
      chk($sformatf("R3 vec%0d valid", i), valid, VEC[i].exp_v);
      if (VEC[i].exp_v) chk($sformatf("R3 vec%0d idx", i), idx, VEC[i].exp_idx);
      if (VEC[i].ack) strobe(1'b1, 1'b0);
      chk($sformatf("R5 vec%0d mask", i), mask, VEC[i].exp_mask);
    end

    // history now 2,1,0 from top
    req = '0; en = 1'b1;
    pull_chk(2, "R6 pull 1");
    pull_chk(1, "R6 pull 2");
    chk("R8 not empty", empty, 0);
    pull_chk(0, "R6 pull 3");
    chk("R8 empty after last pull", empty, 1);
    pull_chk(0, "R8 pull while empty");
    chk("R8 still empty", empty, 1);

    ack_src(8'h02, 1, "R5 push a");
    ack_src(8'h04, 2, "R5 push b");
    ack_src(8'h08, 3, "R5 push c");
    chk("R7 not full at 3", full, 0);
    ack_src(8'h40, 3, "R5 push d");
    chk("R7 full at 4", full, 1);
    ack_src(8'h08, 3, "R7 push while full");
    chk("R7 full kept", full, 1);
    @(negedge clk); req = '0;
    pull_chk(3, "R7 pull e");
    chk("R7 full cleared", full, 0);
    pull_chk(3, "R6 pull d");
    pull_chk(2, "R6 pull c");
    pull_chk(1, "R7 oldest discarded");
    chk("R8 empty", empty, 1);
    pull_chk(1, "R8 empty pull hold");

    set_lvl(7, 3);
    @(negedge clk); req = 8'h80; #1;
    chk("R9 new level seen", lvl, 3);
    chk("R9 idx", idx, 7);
    strobe(1'b1, 1'b1);
    chk("R9 ack wins mask", mask, 3);
    chk("R9 pushed", empty, 0);
    @(negedge clk); req = '0; en = 1'b0;
    strobe(1'b0, 1'b1);
    chk("R4 pull ignored", mask, 3);
    chk("R4 history kept", empty, 0);
    @(negedge clk); en = 1'b1;
    pull_chk(1, "R6 final pull");
    chk("R8 final empty", empty, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule